// File: doc/BRIEF.md
# Selectable-Delay Power-On Reset Timer

This block produces an active-high reset that keeps the rest of a chip in reset after power-up and after any supply dip. A digital supply-good level, driven by an analog threshold comparator outside this block, tells the timer whether the supply is above its trip point. The reset is released only after supply-good has stayed high without a break for a delay chosen by a two-bit select input.

The four delays are given in milliseconds as parameters. They are turned into clock-cycle counts through a clock-frequency parameter, so a bench can use a scaled-down frequency to keep runs short. The reset output is a combination of the supply-good level and a registered "released" state. It is therefore high from time zero whenever supply-good is low, and it rises again at once when the supply drops. When there is no reason to choose otherwise, the select input should be tied to code 01, which gives 100 ms.

Top module: `por_delay_timer`

## Requirements
- R1: `por_o` is 1 whenever `supply_ok` is 0. This holds at time zero, before any clock edge, and it follows a fall of `supply_ok` without waiting for a clock edge.
- R2: Call the first rising clock edge at which `supply_ok` is high edge 1. With the default two synchroniser stages, `por_o` stays 1 through edge N+2 and falls to 0 at edge N+3. N is the selected delay in ms times CLK_HZ/1000.
- R3: The select code `dly_sel` maps to the delay as follows: 2'b00 is DLY0_MS (50), 2'b01 is DLY1_MS (100), 2'b10 is DLY2_MS (200) and 2'b11 is DLY3_MS (300).
- R4: `dly_sel` is sampled once per count, at edge 3 (the edge at which counting starts). A change after that edge has no effect on the running count.
- R5: If `supply_ok` falls at any point before release, the count is discarded and `por_o` stays 1. When `supply_ok` returns, a full new delay is timed, using a freshly sampled code.
- R6: If `supply_ok` falls after release, `por_o` returns to 1 at once, and the next release again takes the full delay of R2.
- R7: Once released, `por_o` stays 0 for as long as `supply_ok` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock at CLK_HZ |
| supply_ok | input | 1 | Supply-above-threshold level, high when the supply is good |
| dly_sel | input | 2 | Release delay code |
| por_o | output | 1 | Active-high reset output |

## Verification
The bench drives inputs on the falling clock edge and counts rising edges from the first one that sees `supply_ok` high. It samples `por_o` at the falling edge after each rising edge. The release is due at rising edge N+3: two synchroniser registers, then one edge to load the count, then N counting edges. The bench expects 1 through edge N+2 and 0 after edge N+3. The reactions to a supply drop are combinational, so they are checked 1 ns after the drop, before any clock edge. The select input is changed right after edge 3 to show that the value already latched is the one that counts.

// File: rtl/por_timer_pkg.sv
package por_timer_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_COUNT = 2'b01,
    PH_DONE  = 2'b10
  } phase_e;

  // Number of clock cycles in a delay of ms milliseconds at hz hertz.
  function automatic longint unsigned ms_to_cycles(longint unsigned ms,
                                                   longint unsigned hz);
    return ms * (hz / 1000);
  endfunction

  function automatic longint unsigned max4(longint unsigned a, longint unsigned b,
                                           longint unsigned c, longint unsigned d);
    longint unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/por_supply_sync.sv
// Brings supply-good into the clock domain. The clear is asynchronous and
// active low on supply_ok itself; the release ripples through STAGES flops.
module por_supply_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic supply_ok,
  output logic good_sync
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_nx;

  always_comb begin
    sh_nx    = sh_q << 1;
    sh_nx[0] = 1'b1;
  end

  always_ff @(posedge clk or negedge supply_ok) begin
    if (!supply_ok) sh_q <= '0;
    else            sh_q <= sh_nx;
  end

  assign good_sync = sh_q[STAGES-1];

endmodule

// File: rtl/por_delay_select.sv
// Turns the two-bit select code into a terminal count.
module por_delay_select #(
  parameter int                   CW     = 8,
  parameter logic [3:0][CW-1:0]   LIMITS = '0
) (
  input  logic [1:0]    sel,
  output logic [CW-1:0] limit
);

  logic [CW-1:0] tbl [4];

  for (genvar g = 0; g < 4; g++) begin : g_tbl
    assign tbl[g] = LIMITS[g];
  end

  assign limit = tbl[sel];

endmodule

// File: rtl/por_hold_counter.sv
// Phase machine and counter. It is held in reset while the synchronised
// supply-good is low. It latches the terminal count when a count starts.
module por_hold_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          run_n,
  input  logic [CW-1:0] limit_in,
  output logic          done,
  output logic          counting,
  output logic [CW-1:0] held_limit
);
  import por_timer_pkg::*;

  phase_e        phase_q, phase_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic [CW-1:0] lim_q, lim_nx;
  logic          cnt_en, lim_en;

  always_comb begin
    phase_nx = phase_q;
    cnt_nx   = cnt_q;
    lim_nx   = lim_q;
    cnt_en   = 1'b0;
    lim_en   = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        phase_nx = PH_COUNT;
        cnt_nx   = CW'(1);
        cnt_en   = 1'b1;
        lim_nx   = limit_in;
        lim_en   = 1'b1;
      end
      PH_COUNT: begin
        if (cnt_q == lim_q) begin
          phase_nx = PH_DONE;
        end else begin
          cnt_nx = cnt_q + CW'(1);
          cnt_en = 1'b1;
        end
      end
      PH_DONE:  phase_nx = PH_DONE;
      default:  phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_nx;
  end

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nx;
  end

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n)      lim_q <= '0;
    else if (lim_en) lim_q <= lim_nx;
  end

  assign done       = (phase_q == PH_DONE);
  assign counting   = (phase_q == PH_COUNT);
  assign held_limit = lim_q;

endmodule

// File: rtl/por_delay_timer.sv
module por_delay_timer #(
  parameter longint unsigned CLK_HZ      = 50_000_000,
  parameter longint unsigned DLY0_MS     = 50,
  parameter longint unsigned DLY1_MS     = 100,
  parameter longint unsigned DLY2_MS     = 200,
  parameter longint unsigned DLY3_MS     = 300,
  parameter int              SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       supply_ok,
  input  logic [1:0] dly_sel,
  output logic       por_o
);
  import por_timer_pkg::*;

  localparam longint unsigned C0   = ms_to_cycles(DLY0_MS, CLK_HZ);
  localparam longint unsigned C1   = ms_to_cycles(DLY1_MS, CLK_HZ);
  localparam longint unsigned C2   = ms_to_cycles(DLY2_MS, CLK_HZ);
  localparam longint unsigned C3   = ms_to_cycles(DLY3_MS, CLK_HZ);
  localparam longint unsigned CMAX = max4(C0, C1, C2, C3);
  localparam int              CW   = $clog2(CMAX + 1);
  localparam logic [3:0][CW-1:0] LIMITS = {CW'(C3), CW'(C2), CW'(C1), CW'(C0)};

  logic          good_sync;
  logic [CW-1:0] sel_limit;
  logic          done_w;
  logic          counting_w;
  logic [CW-1:0] held_limit_w;

  por_supply_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .supply_ok (supply_ok),
    .good_sync (good_sync)
  );

  por_delay_select #(.CW(CW), .LIMITS(LIMITS)) u_sel (
    .sel   (dly_sel),
    .limit (sel_limit)
  );

  por_hold_counter #(.CW(CW)) u_cnt (
    .clk        (clk),
    .run_n      (good_sync),
    .limit_in   (sel_limit),
    .done       (done_w),
    .counting   (counting_w),
    .held_limit (held_limit_w)
  );

  // Combinational with supply_ok, so a drop shows at once and the output
  // is defined before the first edge.
  assign por_o = ~(supply_ok & done_w);

endmodule

// File: rtl/por_delay_timer_chk.sv
module por_delay_timer_chk #(
  parameter int                 CW          = 8,
  parameter int                 SYNC_STAGES = 2,
  parameter logic [3:0][CW-1:0] LIMITS      = '0
) (
  input logic          clk,
  input logic          supply_ok,
  input logic          por_o,
  input logic          counting,
  input logic [CW-1:0] held_limit
);

  localparam int HW = CW + 2;
  localparam logic [HW-1:0] OFS = HW'(SYNC_STAGES + 1);

  logic [HW-1:0] hi_cnt;
  logic [HW-1:0] min_lim;

  always_comb begin
    min_lim = HW'(LIMITS[0]);
    for (int i = 1; i < 4; i++)
      if (HW'(LIMITS[i]) < min_lim) min_lim = HW'(LIMITS[i]);
  end

  // Edges seen with supply_ok high since the last drop, saturating.
  always_ff @(posedge clk or negedge supply_ok) begin
    if (!supply_ok)        hi_cnt <= '0;
    else if (~&hi_cnt)     hi_cnt <= hi_cnt + HW'(1);
  end

  assert_low_supply_holds_R1: assert property (@(posedge clk)
    !supply_ok |-> por_o);

  assert_release_timing_R2: assert property (@(posedge clk) disable iff (!supply_ok)
    $fell(por_o) |-> hi_cnt == HW'(held_limit) + OFS);

  assert_code_map_R3: assert property (@(posedge clk) disable iff (!supply_ok)
    counting |-> (held_limit == LIMITS[0] || held_limit == LIMITS[1] ||
                  held_limit == LIMITS[2] || held_limit == LIMITS[3]));

  assert_sel_frozen_R4: assert property (@(posedge clk) disable iff (!supply_ok)
    (counting && $past(counting)) |-> $stable(held_limit));

  assert_no_early_release_R5: assert property (@(posedge clk) disable iff (!supply_ok)
    !por_o |-> hi_cnt >= min_lim + OFS);

  assert_stays_released_R7: assert property (@(posedge clk) disable iff (!supply_ok)
    !por_o |=> !por_o);

endmodule

bind por_delay_timer por_delay_timer_chk #(
  .CW          (CW),
  .SYNC_STAGES (SYNC_STAGES),
  .LIMITS      (LIMITS)
) u_chk (
  .clk        (clk),
  .supply_ok  (supply_ok),
  .por_o      (por_o),
  .counting   (counting_w),
  .held_limit (held_limit_w)
);

// File: tb/por_delay_timer_test.sv
`timescale 1ns/1ps
module por_delay_timer_test;

  localparam longint unsigned HZ = 1000;  // one cycle per ms

  logic       clk = 1'b0;
  logic       supply_ok;
  logic [1:0] dly_sel;
  logic       por_o;

  int checks = 0;
  int errors = 0;

  por_delay_timer #(.CLK_HZ(HZ)) uut (
    .clk       (clk),
    .supply_ok (supply_ok),
    .dly_sel   (dly_sel),
    .por_o     (por_o)
  );

  always #4 clk = ~clk;

  function automatic int dly(logic [1:0] s);
    int ms;
    case (s)
      2'b00:   ms = 50;
      2'b01:   ms = 100;
      2'b10:   ms = 200;
      default: ms = 300;
    endcase
    return ms * int'(HZ / 1000);
  endfunction

  task automatic check(logic got, logic exp, string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: por_o=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  // Raise supply with code s, switch the code to late after edge 3, and
  // drop supply after edge dip_at (0 = no drop). dipped reports a drop.
  task automatic ramp(logic [1:0] s, int dip_at, logic [1:0] late, output bit dipped);
    int n;
    n = dly(s);
    dipped = 1'b0;
    @(negedge clk);
    dly_sel   = s;
    supply_ok = 1'b1;
    for (int e = 1; e <= n + 3; e++) begin
      @(posedge clk);
      @(negedge clk);
      if (e == 3) dly_sel = late;        // R4: change after sampling edge
      if (dip_at != 0 && e == dip_at) begin
        supply_ok = 1'b0;
        #1 check(por_o, 1'b1, "R5 drop during count");
        dipped = 1'b1;
        return;
      end
      if (e == n + 3)      check(por_o, 1'b0, "R2 R3 R4 release at edge N+3");
      else if (e == n + 2) check(por_o, 1'b1, "R2 R3 still held at edge N+2");
      else                 check(por_o, 1'b1, "R2 held while counting");
    end
  endtask

  task automatic hold_low(int cyc);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      check(por_o, 1'b1, "R1 supply low");
    end
  endtask

  task automatic after_release(int cyc);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      check(por_o, 1'b0, "R7 stays released");
    end
    supply_ok = 1'b0;
    #1 check(por_o, 1'b1, "R6 drop after release");
    hold_low(3);
  endtask

  initial begin
    bit d;
    supply_ok = 1'b0;
    dly_sel   = 2'b01;
    #1 check(por_o, 1'b1, "R1 time zero");
    hold_low(3);

    // Directed: every code, with a different code applied after edge 3.
    for (int s = 0; s < 4; s++) begin
      ramp(2'(s), 0, ~2'(s), d);
      after_release(5);
    end

    // Directed drops: early, mid and the last edge before release.
    ramp(2'b01, 1, 2'b11, d);   hold_low(2);
    ramp(2'b01, 40, 2'b00, d);  hold_low(2);
    ramp(2'b00, 52, 2'b11, d);  hold_low(2);
    ramp(2'b00, 0, 2'b11, d);   after_release(2);   // R5 full count after drop

    // Random runs with a fixed seed.
    void'($urandom(32'h5EED_0042));
    for (int k = 0; k < 14; k++) begin
      logic [1:0] s, late;
      int dip;
      s    = 2'($urandom % 4);
      late = 2'($urandom % 4);
      dip  = ($urandom % 2 == 1) ? 1 + int'($urandom % (dly(s) + 2)) : 0;
      ramp(s, dip, late, d);
      if (d) hold_low(1 + int'($urandom % 3));
      else   after_release(1 + int'($urandom % 6));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule